// File: doc/BRIEF.md
# GPIO Control Subpacket Processor

This block sits behind a control-channel receiver and services the GPIO commands that arrive there. Frames come in one byte per cycle, with markers on the first and last byte. Each frame packs one or more subpackets end to end. Every subpacket starts with a four-byte header: opcode, length, request id and bank. The block uses the length byte to step from one subpacket to the next. A subpacket whose opcode it does not own is skipped.

For each GPIO command the block raises one single-cycle write strobe toward a GPIO bank. The strobe comes with the bank number, the 16-bit value, the 16-bit mask and, for a pin-select command, the sixteen select bytes. It then sends a reply subpacket on a byte-wide output stream.

- A read command returns an eight-byte reply that carries the bank value sampled in the strobe cycle.
- Every other GPIO command returns a four-byte acknowledge.
- Each reply echoes the request id and has bit 7 of the opcode set.
- Each frame comes with a reply byte budget. A reply that does not fit the budget is dropped, but the command itself still executes.

Top module: `gpio_subpkt_proc`

## Requirements
- R1: After reset, `out_valid` and all five strobes are low, and they stay low until a complete command subpacket has arrived.
- R2: Opcode 17 with a length of at least 12 raises `gpio_dir_we` for one cycle. This is the cycle after the last byte of the subpacket. In that cycle `gpio_bank` holds byte 3, `gpio_value` holds bytes 4..5 and `gpio_mask` holds bytes 6..7, both big-endian. The acknowledge is {0x91, 0x04, request id, 0x01}.
- R3: Opcode 20 with a length of at least 12 raises `gpio_wr_we` with the same field positions as R2. The acknowledge is {0x94, 0x04, request id, 0x01}.
- R4: Opcode 21 with a length of at least 12 raises `gpio_stream_we` with the same field positions as R2. The acknowledge is {0x95, 0x04, request id, 0x01}.
- R5: Opcode 18 with a length of at least 20 raises `gpio_sel_we`. Select entry k is taken from subpacket byte 4+k and appears on `gpio_sels[8k+7:8k]`. The acknowledge is {0x92, 0x04, request id, 0x01}.
- R6: Opcode 19 with a length of at least 12 raises `gpio_rd_req` with `gpio_bank` set to byte 3. `gpio_rd_data` is sampled in that same cycle. The reply is {0x93, 0x08, request id, 0x01, 0x00, 0x00, data[15:8], data[7:0]}.
- R7: The first reply byte appears on `out_valid` in the cycle after the strobe. The remaining bytes follow on consecutive cycles, and `out_last` marks only the final byte.
- R8: Subpackets within a frame are walked by their length byte. Bytes beyond a command's minimum size are padding with no effect. Gaps in `in_valid` do not change the result.
- R9: A subpacket is skipped without strobe or reply in two cases: an opcode outside 17..21, or a GPIO opcode with a length below its minimum (12, or 20 for opcode 18).
- R10: A length byte below 4 stops parsing. The rest of the frame is ignored.
- R11: A subpacket cut short by the end-of-frame marker produces no strobe and no reply. Bytes that arrive after the end of a frame without a start marker are ignored.
- R12: `reply_space` is sampled with the first byte of each frame. A reply is sent only if its size does not exceed the bytes still available, and a sent reply uses up its size. The command's strobe is raised whether or not its reply fits.
- R13: A new frame may start in the same cycle that the previous frame's last command executes. That command is judged against the old frame's remaining space, and the new frame starts with its own budget.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| reply_space | input | 8 | Reply byte budget, sampled with the first byte of a frame |
| gpio_rd_data | input | 16 | Bank value, sampled while `gpio_rd_req` is high |
| gpio_bank | output | 8 | Target bank of the current command |
| gpio_value | output | 16 | Command value field |
| gpio_mask | output | 16 | Command mask field |
| gpio_sels | output | NUM_SEL*8 | Pin select entries, entry k in bits [8k+7:8k] |
| gpio_dir_we | output | 1 | Direction write strobe |
| gpio_sel_we | output | 1 | Pin select write strobe |
| gpio_rd_req | output | 1 | Bank read strobe |
| gpio_wr_we | output | 1 | Output value write strobe |
| gpio_stream_we | output | 1 | Stream-enable write strobe |
| out_valid | output | 1 | Reply byte valid |
| out_data | output | 8 | Reply byte |
| out_last | output | 1 | Last byte of a reply subpacket |

## Verification
Two pairs of events can land in the same cycle.

- Execution of one command coincides with the header bytes of the next subpacket.
- Execution of a frame's last command coincides with the start marker of the next frame, which reloads the reply budget.

The first pair is provoked in every multi-subpacket frame. The second is provoked by sending two frames with no idle cycle between them, over several pairs of budgets. A bench model walks the same bytes by the requirement rules and predicts the strobe list and reply bytes. Each reply's first byte must appear exactly one cycle after its strobe, and the old frame's reply must be accepted or dropped against the old budget.

// File: rtl/gsp_pkg.sv
// Package: shared constants of the GPIO subpacket processor.
// Assumes byte-wide headers and big-endian 16-bit fields.
package gsp_pkg;
    localparam logic [7:0] OP_DIR     = 8'd17;
    localparam logic [7:0] OP_SEL     = 8'd18;
    localparam logic [7:0] OP_RD      = 8'd19;
    localparam logic [7:0] OP_WR      = 8'd20;
    localparam logic [7:0] OP_STRM    = 8'd21;
    localparam logic [7:0] REPLY_FLAG = 8'h80;
    localparam logic [7:0] HDR_LEN    = 8'd4;
    localparam logic [7:0] CMD_LEN    = 8'd12;
    localparam logic [7:0] ACK_LEN    = 8'd4;
    localparam logic [7:0] RDREP_LEN  = 8'd8;
    localparam int unsigned VAL_W     = 16;
    localparam int unsigned REP_BYTES = 8;
endpackage

// File: rtl/gsp_parser.sv
// Module: gsp_parser
// Walks subpackets in a byte stream and captures header and body fields.
// Raises done for one cycle after the last byte of each complete subpacket.
// Assumes a subpacket length of at least HDR_LEN; a smaller length halts
// the frame. Fields hold their value until the next subpacket overwrites them.
module gsp_parser
    import gsp_pkg::*;
#(
    parameter int unsigned NUM_SEL = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [7:0]           in_data,
    input  logic                 in_sof,
    input  logic                 in_eof,
    output logic                 done,
    output logic [7:0]           f_op,
    output logic [7:0]           f_len,
    output logic [7:0]           f_rid,
    output logic [7:0]           f_bank,
    output logic [VAL_W-1:0]     f_val,
    output logic [VAL_W-1:0]     f_msk,
    output logic [NUM_SEL*8-1:0] f_sels
);
    localparam int unsigned SEL_W = NUM_SEL * 8;

    logic       active_q;
    logic [7:0] idx_q;
    logic [7:0] pos;
    logic       take;
    logic       halt_now;
    logic       end_now;

    // Position of the current byte inside its subpacket, and frame decisions.
    always_comb begin
        pos      = in_sof ? 8'd0 : idx_q;
        take     = in_valid && (in_sof || active_q);
        halt_now = (pos == 8'd1) && (in_data < HDR_LEN);
        end_now  = (pos >= 8'd3) && (pos == f_len - 8'd1);
    end

    // Frame/subpacket walk state and the one-cycle completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            idx_q    <= 8'd0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (take) begin
                active_q <= !(halt_now || in_eof);
                if (end_now) begin
                    done  <= 1'b1;
                    idx_q <= 8'd0;
                end else begin
                    idx_q <= pos + 8'd1;
                end
            end
        end
    end

    // Header and fixed-position body field capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_op   <= 8'd0;
            f_len  <= 8'd0;
            f_rid  <= 8'd0;
            f_bank <= 8'd0;
            f_val  <= '0;
            f_msk  <= '0;
        end else if (take) begin
            case (pos)
                8'd0: f_op   <= in_data;
                8'd1: f_len  <= in_data;
                8'd2: f_rid  <= in_data;
                8'd3: f_bank <= in_data;
                8'd4: f_val[15:8] <= in_data;
                8'd5: f_val[7:0]  <= in_data;
                8'd6: f_msk[15:8] <= in_data;
                8'd7: f_msk[7:0]  <= in_data;
                default: ;
            endcase
        end
    end

    // Select entry capture: entry k comes from body byte HDR_LEN+k.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_sels <= '0;
        end else if (take) begin
            for (int k = 0; k < NUM_SEL; k++) begin
                if (pos == 8'(4 + k)) f_sels[k*8 +: 8] <= in_data;
            end
        end
    end

    // R8
    // completion never repeats on consecutive cycles, since lengths are at least 4
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    // a halting length byte leaves the walker inactive for the rest of the frame
    halt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && halt_now && !in_sof) |=> !active_q);

    logic unused_w;
    assign unused_w = ^SEL_W;
endmodule

// File: rtl/gsp_exec.sv
// Module: gsp_exec
// Decodes a completed subpacket, raises one GPIO strobe for a valid
// command, keeps the per-frame reply budget, and builds the reply bytes.
// Assumes done is a single-cycle pulse with the fields stable while it is high.
module gsp_exec
    import gsp_pkg::*;
#(
    parameter int unsigned NUM_SEL = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   done,
    input  logic [7:0]             f_op,
    input  logic [7:0]             f_len,
    input  logic [7:0]             f_rid,
    input  logic [VAL_W-1:0]       rd_data,
    input  logic                   frame_start,
    input  logic [7:0]             reply_space,
    output logic                   dir_we,
    output logic                   sel_we,
    output logic                   rd_req,
    output logic                   wr_we,
    output logic                   stream_we,
    output logic                   rep_load,
    output logic [REP_BYTES*8-1:0] rep_bytes,
    output logic [3:0]             rep_size
);
    localparam logic [7:0] SEL_LEN = 8'(4 + NUM_SEL);

    logic [7:0] space_q;
    logic       known;
    logic [7:0] need;
    logic       cmd_ok;
    logic [7:0] rsz;
    logic       fits;

    // Command validity, strobe selection and reply admission.
    always_comb begin
        known     = (f_op >= OP_DIR) && (f_op <= OP_STRM);
        need      = (f_op == OP_SEL) ? SEL_LEN : CMD_LEN;
        cmd_ok    = done && known && (f_len >= need);
        rsz       = (f_op == OP_RD) ? RDREP_LEN : ACK_LEN;
        fits      = rsz <= space_q;
        dir_we    = cmd_ok && (f_op == OP_DIR);
        sel_we    = cmd_ok && (f_op == OP_SEL);
        rd_req    = cmd_ok && (f_op == OP_RD);
        wr_we     = cmd_ok && (f_op == OP_WR);
        stream_we = cmd_ok && (f_op == OP_STRM);
        rep_load  = cmd_ok && fits;
        rep_size  = rsz[3:0];
    end

    // Reply byte image, byte k in bits [8k+7:8k].
    always_comb begin
        rep_bytes        = '0;
        rep_bytes[7:0]   = f_op | REPLY_FLAG;
        rep_bytes[15:8]  = rsz;
        rep_bytes[23:16] = f_rid;
        rep_bytes[31:24] = 8'd1;
        rep_bytes[55:48] = rd_data[15:8];
        rep_bytes[63:56] = rd_data[7:0];
    end

    // Reply budget: reloaded at frame start, consumed by each sent reply.
    always_ff @(posedge clk) begin
        if (!rst_n)           space_q <= 8'd0;
        else if (frame_start) space_q <= reply_space;
        else if (rep_load)    space_q <= space_q - rsz;
    end

    // R9
    // at most one strobe toward the bank in any cycle
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dir_we, sel_we, rd_req, wr_we, stream_we}));

    // R12
    // the budget only shrinks within a frame
    space_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> space_q <= $past(space_q));

    // R1
    // no strobe without a completed subpacket
    strobe_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_we || sel_we || rd_req || wr_we || stream_we) |-> done);
endmodule

// File: rtl/gsp_reply_tx.sv
// Module: gsp_reply_tx
// Holds one reply subpacket and shifts it out one byte per cycle.
// Assumes a new reply is loaded only after the previous one has drained,
// which the minimum command length guarantees.
module gsp_reply_tx
    import gsp_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rep_load,
    input  logic [REP_BYTES*8-1:0] rep_bytes,
    input  logic [3:0]             rep_size,
    output logic                   out_valid,
    output logic [7:0]             out_data,
    output logic                   out_last
);
    logic [REP_BYTES*8-1:0] buf_q;
    logic [3:0]             cnt_q;

    // Load a reply image or shift the next byte into the output slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
            cnt_q <= 4'd0;
        end else if (rep_load) begin
            buf_q <= rep_bytes;
            cnt_q <= rep_size;
        end else if (cnt_q != 4'd0) begin
            buf_q <= {8'd0, buf_q[REP_BYTES*8-1:8]};
            cnt_q <= cnt_q - 4'd1;
        end
    end

    // Output byte view of the shift buffer.
    always_comb begin
        out_valid = cnt_q != 4'd0;
        out_data  = buf_q[7:0];
        out_last  = cnt_q == 4'd1;
    end

    // R7
    // a reply is never loaded over one still draining
    reply_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rep_load |-> cnt_q == 4'd0);

    // R7
    // reply bytes are contiguous until the last one
    reply_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> out_valid);
endmodule

// File: rtl/gpio_subpkt_proc.sv
// Module: gpio_subpkt_proc (top)
// GPIO control subpacket processor: parser walks subpackets, exec issues
// strobes and admits replies, reply_tx streams the reply bytes.
// Assumes no back-pressure on the reply stream.
module gpio_subpkt_proc
    import gsp_pkg::*;
#(
    parameter int unsigned NUM_SEL = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [7:0]           in_data,
    input  logic                 in_sof,
    input  logic                 in_eof,
    input  logic [7:0]           reply_space,
    input  logic [15:0]          gpio_rd_data,
    output logic [7:0]           gpio_bank,
    output logic [15:0]          gpio_value,
    output logic [15:0]          gpio_mask,
    output logic [NUM_SEL*8-1:0] gpio_sels,
    output logic                 gpio_dir_we,
    output logic                 gpio_sel_we,
    output logic                 gpio_rd_req,
    output logic                 gpio_wr_we,
    output logic                 gpio_stream_we,
    output logic                 out_valid,
    output logic [7:0]           out_data,
    output logic                 out_last
);
    logic                   done;
    logic [7:0]             f_op;
    logic [7:0]             f_len;
    logic [7:0]             f_rid;
    logic                   rep_load;
    logic [REP_BYTES*8-1:0] rep_bytes;
    logic [3:0]             rep_size;
    logic                   frame_start;

    assign frame_start = in_valid && in_sof;

    gsp_parser #(.NUM_SEL(NUM_SEL)) u_parser (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
        .done(done), .f_op(f_op), .f_len(f_len), .f_rid(f_rid),
        .f_bank(gpio_bank), .f_val(gpio_value), .f_msk(gpio_mask), .f_sels(gpio_sels)
    );

    gsp_exec #(.NUM_SEL(NUM_SEL)) u_exec (
        .clk(clk), .rst_n(rst_n),
        .done(done), .f_op(f_op), .f_len(f_len), .f_rid(f_rid),
        .rd_data(gpio_rd_data), .frame_start(frame_start), .reply_space(reply_space),
        .dir_we(gpio_dir_we), .sel_we(gpio_sel_we), .rd_req(gpio_rd_req),
        .wr_we(gpio_wr_we), .stream_we(gpio_stream_we),
        .rep_load(rep_load), .rep_bytes(rep_bytes), .rep_size(rep_size)
    );

    gsp_reply_tx u_tx (
        .clk(clk), .rst_n(rst_n),
        .rep_load(rep_load), .rep_bytes(rep_bytes), .rep_size(rep_size),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
    );
endmodule

// File: tb/sim_gpio_subpkt_proc.sv
module sim_gpio_subpkt_proc;
    localparam int NSEL = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'd0;
    logic        in_sof = 1'b0;
    logic        in_eof = 1'b0;
    logic [7:0]  reply_space = 8'd0;
    logic [15:0] gpio_rd_data;
    logic [7:0]  gpio_bank;
    logic [15:0] gpio_value, gpio_mask;
    logic [NSEL*8-1:0] gpio_sels;
    logic gpio_dir_we, gpio_sel_we, gpio_rd_req, gpio_wr_we, gpio_stream_we;
    logic out_valid, out_last;
    logic [7:0] out_data;

    always #4 clk = ~clk;

    assign gpio_rd_data = {gpio_bank ^ 8'h5A, ~gpio_bank};

    gpio_subpkt_proc #(.NUM_SEL(NSEL)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof), .reply_space(reply_space),
        .gpio_rd_data(gpio_rd_data), .gpio_bank(gpio_bank), .gpio_value(gpio_value),
        .gpio_mask(gpio_mask), .gpio_sels(gpio_sels), .gpio_dir_we(gpio_dir_we),
        .gpio_sel_we(gpio_sel_we), .gpio_rd_req(gpio_rd_req), .gpio_wr_we(gpio_wr_we),
        .gpio_stream_we(gpio_stream_we), .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int errors = 0, checks = 0;
    logic [7:0] fb [0:511];

    // observed log
    int got_n = 0, rb_n = 0;
    int got_k [0:63]; int got_c [0:63];
    logic [7:0] got_b [0:63]; logic [15:0] got_v [0:63]; logic [15:0] got_m [0:63];
    logic [NSEL*8-1:0] got_s [0:63];
    logic [7:0] rb [0:255]; int rb_c [0:255]; bit rb_l [0:255];
    // expected log
    int en = 0, ern = 0, erepn = 0;
    int ek [0:63]; logic [7:0] eb [0:63]; logic [15:0] ev [0:63]; logic [15:0] em [0:63];
    logic [NSEL*8-1:0] es [0:63];
    logic [7:0] erb [0:255]; int erep_ev [0:63]; int erep_st [0:63]; int erep_sz [0:63];

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // monitor: strobes and reply bytes, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            int c;
            c = int'(gpio_dir_we) + int'(gpio_sel_we) + int'(gpio_rd_req) + int'(gpio_wr_we) + int'(gpio_stream_we);
            if (c != 0 && got_n < 64) begin
                got_k[got_n] = (c > 1) ? 9 : gpio_dir_we ? 1 : gpio_sel_we ? 2 :
                               gpio_rd_req ? 3 : gpio_wr_we ? 4 : 5;
                got_b[got_n] = gpio_bank; got_v[got_n] = gpio_value;
                got_m[got_n] = gpio_mask; got_s[got_n] = gpio_sels;
                got_c[got_n] = cyc; got_n++;
            end
            if (out_valid && rb_n < 256) begin
                rb[rb_n] = out_data; rb_c[rb_n] = cyc; rb_l[rb_n] = out_last; rb_n++;
            end
        end
    end

    task automatic clear_logs();
        got_n = 0; rb_n = 0; en = 0; ern = 0; erepn = 0;
    endtask

    // requirement model: walk fb[off .. off+n-1] with budget sp
    task automatic model(input int off, input int n, input int sp);
        int s, len, op, need, sz, k;
        s = 0;
        while (1) begin
            if (s + 1 >= n) break;
            len = fb[off+s+1];
            if (len < 4) break;
            if (s + len > n) break;
            op = fb[off+s];
            need = (op == 18) ? 20 : 12;
            if (op >= 17 && op <= 21 && len >= need) begin
                ek[en] = (op == 17) ? 1 : (op == 18) ? 2 : (op == 19) ? 3 : (op == 20) ? 4 : 5;
                eb[en] = fb[off+s+3];
                ev[en] = {fb[off+s+4], fb[off+s+5]};
                em[en] = {fb[off+s+6], fb[off+s+7]};
                es[en] = '0;
                if (op == 18) for (k = 0; k < NSEL; k++) es[en][k*8 +: 8] = fb[off+s+4+k];
                sz = (op == 19) ? 8 : 4;
                if (sz <= sp) begin
                    erep_ev[erepn] = en; erep_st[erepn] = ern; erep_sz[erepn] = sz; erepn++;
                    erb[ern] = 8'(op) | 8'h80; erb[ern+1] = 8'(sz); erb[ern+2] = fb[off+s+2];
                    erb[ern+3] = 8'd1;
                    if (sz == 8) begin
                        erb[ern+4] = 8'd0; erb[ern+5] = 8'd0;
                        erb[ern+6] = eb[en] ^ 8'h5A; erb[ern+7] = ~eb[en];
                    end
                    ern += sz; sp -= sz;
                end
                en++;
            end
            s += len;
        end
    endtask

    task automatic send(input int off, input int n, input int sp, input bit gap, input bit drain);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = fb[off+i];
            in_sof = (i == 0); in_eof = (i == n - 1);
            reply_space = (i == 0) ? 8'(sp) : 8'hEE;
            if (gap && (i % 3 == 2) && i != n - 1) begin
                @(negedge clk); in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
            end
        end
        if (drain) begin
            @(negedge clk); in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
            repeat (14) @(negedge clk);
        end
    endtask

    function automatic string ktag(input int k);
        case (k)
            1: return "R2"; 2: return "R5"; 3: return "R6"; 4: return "R3"; default: return "R4";
        endcase
    endfunction

    task automatic compare(input string tag);
        check(got_n == en, tag, "strobe count", got_n, en);
        for (int i = 0; i < en && i < got_n; i++) begin
            check(got_k[i] == ek[i], ktag(ek[i]), "strobe kind", got_k[i], ek[i]);
            check(got_b[i] == eb[i], ktag(ek[i]), "bank", got_b[i], eb[i]);
            if (ek[i] != 2 && ek[i] != 3) begin
                check(got_v[i] == ev[i], ktag(ek[i]), "value", got_v[i], ev[i]);
                check(got_m[i] == em[i], ktag(ek[i]), "mask", got_m[i], em[i]);
            end
            if (ek[i] == 2) check(got_s[i] == es[i], "R5", "selects", got_s[i], es[i]);
        end
        check(rb_n == ern, tag, "reply byte count", rb_n, ern);
        for (int i = 0; i < ern && i < rb_n; i++)
            check(rb[i] == erb[i], tag, "reply byte", rb[i], erb[i]);
        for (int r = 0; r < erepn; r++) begin
            int st, e;
            st = erep_st[r]; e = erep_ev[r];
            if (st + erep_sz[r] <= rb_n && e < got_n) begin
                check(rb_c[st] == got_c[e] + 1, "R7", "reply start cycle", rb_c[st], got_c[e] + 1);
                for (int j = 0; j < erep_sz[r]; j++) begin
                    check(rb_c[st+j] == rb_c[st] + j, "R7", "reply contiguity", rb_c[st+j], rb_c[st] + j);
                    check(rb_l[st+j] == (j == erep_sz[r] - 1), "R7", "last flag", rb_l[st+j], (j == erep_sz[r] - 1));
                end
            end
        end
    endtask

    // fill a subpacket at fb[p] and return its size in bytes
    function automatic int put_sub(input int p, input int op, input int len, input int seed);
        int sz;
        sz = (len < 4) ? 4 : len;
        fb[p] = 8'(op); fb[p+1] = 8'(len);
        for (int k = 2; k < sz; k++) fb[p+k] = 8'(seed * 7 + k * 13 + len * 3);
        return sz;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int lens [10] = '{0, 2, 4, 8, 11, 12, 16, 19, 20, 24};
        int p, n;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        check({gpio_dir_we, gpio_sel_we, gpio_rd_req, gpio_wr_we, gpio_stream_we} == 5'd0,
              "R1", "strobes in reset", {gpio_dir_we, gpio_sel_we, gpio_rd_req, gpio_wr_we, gpio_stream_we}, 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(out_valid == 1'b0 && got_n == 0, "R1", "idle after reset", {out_valid, got_n[7:0]}, 0);

        // R8 R9 R10: opcode x length sweep, followed by a write subpacket
        for (int op = 0; op < 32; op++) begin
            for (int li = 0; li < 10; li++) begin
                string t;
                clear_logs();
                p = put_sub(0, op, lens[li], op + li);
                n = p + put_sub(p, 20, 12, op ^ li);
                t = (lens[li] < 4) ? "R10" : (op >= 17 && op <= 21 && lens[li] >= ((op == 18) ? 20 : 12)) ? "R8" : "R9";
                model(0, n, 255);
                send(0, n, 255, op[0], 1'b1);
                compare(t);
            end
        end

        // R12: reply budget sweep
        for (int sp = 0; sp <= 28; sp++) begin
            clear_logs();
            p = put_sub(0, 19, 12, sp);
            p += put_sub(p, 17, 12, sp + 1);
            p += put_sub(p, 19, 16, sp + 2);
            n = p + put_sub(p, 20, 12, sp + 3);
            model(0, n, sp);
            send(0, n, sp, 1'b0, 1'b1);
            compare("R12");
        end

        // R11: truncated frames followed by stray bytes without a start marker
        for (int cut = 1; cut < 32; cut++) begin
            clear_logs();
            p = put_sub(0, 20, 12, cut);
            void'(put_sub(p, 18, 20, cut + 5));
            model(0, cut, 255);
            send(0, cut, 255, 1'b0, 1'b0);
            for (int i = 0; i < 24; i++) begin
                @(negedge clk); in_valid = 1'b1; in_sof = 1'b0; in_eof = 1'b0;
                in_data = fb[i % 12];
            end
            @(negedge clk); in_valid = 1'b0;
            repeat (14) @(negedge clk);
            compare("R11");
        end

        // R13: back-to-back frames, last command of A executes with B's start
        for (int sa = 8; sa <= 20; sa += 4) begin
            for (int sb = 0; sb <= 12; sb += 4) begin
                int na, nb;
                clear_logs();
                p = put_sub(0, 17, 12, sa);
                p += put_sub(p, 20, 12, sb);
                na = p + put_sub(p, 19, 12, sa + sb);
                p = put_sub(256, 19, 12, sb + 9);
                nb = p + put_sub(256 + p, 21, 12, sa + 9);
                model(0, na, sa);
                model(256, nb, sb);
                send(0, na, sa, 1'b0, 1'b0);
                send(256, nb, sb, 1'b0, 1'b1);
                compare("R13");
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule